// File: doc/BRIEF.md
# Instruction fetch forwarding throttle

This block sits on the path from an instruction cache's fetch output to the dispatch stage. It lowers the rate at which fetched words are handed on, so that downstream units spend more cycles idle and can power down. Clock and PLL settings are never touched. The only lever is holding back the valid/ready handshake for a programmable number of clocks after each accepted transfer.

Software controls the block through one 32-bit control word behind a special-register access port. Only a supervisor access at register number 1019 reaches the word. Any other access is refused and flagged. A change to the enable or to the gap length acts on the cycle right after the write. A gap already running is cut short or ended at once; it is never drained under the old setting.

Top module: `fetch_throttle`

## Requirements
- R1: After reset the enable and the gap length are zero, forwarding is unthrottled and the control word reads back as 0x00000000.
- R2: In the control word, bit 0 is the enable and bits 8:1 are the gap length in clocks, with bit 8 as its most significant bit. Bits 31:9 ignore writes and always read as zero.
- R3: An access reaches the control word only when the strobe is high, the supervisor flag is high and the register number is 1019. Read data appears on `sr_rdata` in the cycle after the access strobe.
- R4: Every other access leaves the control word unchanged, returns zero read data, and raises `sr_err` for exactly one cycle, in the cycle after the access.
- R5: With the enable clear, `dn_valid` follows `up_valid` and `up_ready` follows `dn_ready` in the same cycle, with no gap.
- R6: With the enable set and gap length N, every accepted transfer (`up_valid` and `up_ready` both high) is followed by exactly N cycles with `dn_valid` and `up_ready` held low. The next transfer can be accepted in the cycle after those N cycles.
- R7: With the enable set and a gap length of 0, forwarding is cycle-for-cycle the same as with the enable clear.
- R8: A write that clears the enable ends any running gap. Forwarding is open from the cycle after the write.
- R9: A write that lowers the gap length below the remaining gap clamps the remaining gap to the new length, counted from the cycle after the write.
- R10: `dn_data` always equals `up_data`.
- R11: When a control write and an accepted transfer fall in the same cycle, the gap after that transfer uses the newly written length.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| sr_valid | input | 1 | Special-register access strobe |
| sr_write | input | 1 | 1 = write, 0 = read |
| sr_num | input | 10 | Special-register number |
| sr_super | input | 1 | Supervisor privilege flag |
| sr_wdata | input | 32 | Write data |
| sr_rdata | output | 32 | Read data, one cycle after the access |
| sr_err | output | 1 | One-cycle pulse for a refused access |
| up_valid | input | 1 | Fetch word available from the cache |
| up_data | input | 32 | Fetch word |
| up_ready | output | 1 | Fetch word accepted this cycle when high with `up_valid` |
| dn_valid | output | 1 | Fetch word offered to dispatch |
| dn_data | output | 32 | Fetch word to dispatch |
| dn_ready | input | 1 | Dispatch can take a word |

## Verification
The control write and the accepted transfer can land on the same clock edge. There the counter's load value must come from the incoming control word, not the stored one. The bench provokes this by raising `up_valid`, `dn_ready` and a supervisor write with a new gap length in one cycle. It then judges the result by counting the closed cycles that follow against the new length. A second collision, a write arriving while a gap is still running, is forced with a long gap followed by a shorter or disabling write. There the bench checks that the handshake reopens after the clamped count.

// File: rtl/ft_pkg.sv
package ft_pkg;
  localparam int unsigned CTRL_W  = 32;
  localparam int unsigned FI_W    = 8;
  localparam int unsigned EN_POS  = 0;
  localparam int unsigned FI_LSB  = 1;
  localparam int unsigned RSV_LSB = FI_LSB + FI_W;

  typedef struct packed {
    logic [FI_W-1:0] fi;
    logic            en;
  } ctrl_t;
endpackage

// File: rtl/ft_ctrl_reg.sv
module ft_ctrl_reg
  import ft_pkg::*;
#(
  parameter int unsigned SPR_W  = 10,
  parameter int unsigned SPR_ID = 1019
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc_vld,
  input  logic              acc_wr,
  input  logic [SPR_W-1:0]  acc_num,
  input  logic              acc_sup,
  input  logic [CTRL_W-1:0] acc_wdata,
  output logic [CTRL_W-1:0] rdata_q,
  output logic              err_q,
  output ctrl_t             ctrl_q,
  output ctrl_t             ctrl_nxt
);
  logic              hit;
  logic              wr_hit;
  logic [CTRL_W-1:0] rdata_nxt;
  logic              err_nxt;

  always_comb begin
    hit    = acc_vld && acc_sup && (acc_num == SPR_W'(SPR_ID));
    wr_hit = hit && acc_wr;
    ctrl_nxt = ctrl_q;
    if (wr_hit) begin
      ctrl_nxt.en = acc_wdata[EN_POS];
      ctrl_nxt.fi = acc_wdata[FI_LSB +: FI_W];
    end
    rdata_nxt = '0;
    if (hit && !acc_wr) begin
      rdata_nxt[EN_POS]          = ctrl_q.en;
      rdata_nxt[FI_LSB +: FI_W]  = ctrl_q.fi;
    end
    err_nxt = acc_vld && !hit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q  <= '0;
      rdata_q <= '0;
      err_q   <= 1'b0;
    end else begin
      ctrl_q  <= ctrl_nxt;
      rdata_q <= rdata_nxt;
      err_q   <= err_nxt;
    end
  end

  // R4: a refused write leaves the stored control word as it was
  p_refused_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_vld && acc_wr && !(acc_sup && acc_num == SPR_W'(SPR_ID))) |=> $stable(ctrl_q));

  // R2: reserved read bits stay zero after any read
  p_rsv_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_vld && !acc_wr) |=> (rdata_q[CTRL_W-1:RSV_LSB] == '0));
endmodule

// File: rtl/ft_gap_ctr.sv
module ft_gap_ctr
  import ft_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  xfer,
  input  ctrl_t ctrl_q,
  input  ctrl_t ctrl_nxt,
  output logic  busy
);
  logic [FI_W-1:0] cnt_q;
  logic [FI_W-1:0] cnt_nxt;
  logic [FI_W-1:0] base;

  always_comb begin
    if (xfer)
      base = ctrl_nxt.en ? ctrl_nxt.fi : '0;
    else if (cnt_q != '0)
      base = cnt_q - 1'b1;
    else
      base = '0;
    if (!ctrl_nxt.en)
      cnt_nxt = '0;
    else if (base > ctrl_nxt.fi)
      cnt_nxt = ctrl_nxt.fi;
    else
      cnt_nxt = base;
    busy = (cnt_q != '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_nxt;
  end

  // R9: remaining gap never exceeds the programmed length
  p_gap_bound_r9: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= ctrl_q.fi);

  // R8: clearing the enable ends the gap from the next cycle
  p_disable_opens_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_nxt.en |=> !busy);
endmodule

// File: rtl/fetch_throttle.sv
module fetch_throttle
  import ft_pkg::*;
#(
  parameter int unsigned SPR_W  = 10,
  parameter int unsigned SPR_ID = 1019,
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sr_valid,
  input  logic              sr_write,
  input  logic [SPR_W-1:0]  sr_num,
  input  logic              sr_super,
  input  logic [CTRL_W-1:0] sr_wdata,
  output logic [CTRL_W-1:0] sr_rdata,
  output logic              sr_err,
  input  logic              up_valid,
  input  logic [DATA_W-1:0] up_data,
  output logic              up_ready,
  output logic              dn_valid,
  output logic [DATA_W-1:0] dn_data,
  input  logic              dn_ready
);
  logic [1:0] rst_sync_q;
  logic       rst_q;
  ctrl_t      ctrl_q;
  ctrl_t      ctrl_nxt;
  logic       busy;
  logic       xfer;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_q = rst_sync_q[1];

  ft_ctrl_reg #(.SPR_W(SPR_W), .SPR_ID(SPR_ID)) u_reg (
    .clk      (clk),
    .rst_n    (rst_q),
    .acc_vld  (sr_valid),
    .acc_wr   (sr_write),
    .acc_num  (sr_num),
    .acc_sup  (sr_super),
    .acc_wdata(sr_wdata),
    .rdata_q  (sr_rdata),
    .err_q    (sr_err),
    .ctrl_q   (ctrl_q),
    .ctrl_nxt (ctrl_nxt)
  );

  ft_gap_ctr u_ctr (
    .clk     (clk),
    .rst_n   (rst_q),
    .xfer    (xfer),
    .ctrl_q  (ctrl_q),
    .ctrl_nxt(ctrl_nxt),
    .busy    (busy)
  );

  always_comb begin
    dn_valid = up_valid && !busy;
    up_ready = dn_ready && !busy;
    dn_data  = up_data;
    xfer     = up_valid && dn_ready && !busy;
  end

  // R5: unthrottled path while disabled
  p_full_rate_r5: assert property (@(posedge clk) disable iff (!rst_q)
    !ctrl_q.en |-> (dn_valid == up_valid && up_ready == dn_ready));

  // R6: a nonzero gap closes the handshake right after a transfer
  p_gap_closes_r6: assert property (@(posedge clk) disable iff (!rst_q)
    (up_valid && up_ready && ctrl_nxt.en && ctrl_nxt.fi != '0) |=> (!dn_valid && !up_ready));

  // R10: payload is untouched
  p_data_pass_r10: assert property (@(posedge clk) disable iff (!rst_q)
    dn_data == up_data);
endmodule

// File: tb/sim_fetch_throttle.sv
module sim_fetch_throttle;
  localparam int CLK_PERIOD = 10;
  localparam int ID = 1019;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        sr_valid, sr_write, sr_super;
  logic [9:0]  sr_num;
  logic [31:0] sr_wdata, sr_rdata;
  logic        sr_err;
  logic        up_valid, up_ready, dn_valid, dn_ready;
  logic [31:0] up_data, dn_data;

  int total = 0;
  int bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  fetch_throttle u0 (
    .clk(clk), .rst_n(rst_n),
    .sr_valid(sr_valid), .sr_write(sr_write), .sr_num(sr_num),
    .sr_super(sr_super), .sr_wdata(sr_wdata), .sr_rdata(sr_rdata),
    .sr_err(sr_err),
    .up_valid(up_valid), .up_data(up_data), .up_ready(up_ready),
    .dn_valid(dn_valid), .dn_data(dn_data), .dn_ready(dn_ready)
  );

  task automatic tick();
    @(negedge clk); #2;
  endtask

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  task automatic acc(input bit wr, input int num, input bit sup, input logic [31:0] d,
                     output logic [31:0] rd, output logic er);
    sr_valid = 1'b1; sr_write = wr; sr_num = 10'(num); sr_super = sup; sr_wdata = d;
    tick();
    rd = sr_rdata; er = sr_err;
    sr_valid = 1'b0; sr_write = 1'b0;
  endtask

  task automatic wr_ok(input logic [31:0] d);
    logic [31:0] rd; logic er;
    acc(1'b1, ID, 1'b1, d, rd, er);
  endtask

  task automatic rd_ok(output logic [31:0] rd);
    logic er;
    acc(1'b0, ID, 1'b1, '0, rd, er);
  endtask

  // Gap between the first two transfers with a constant offer and demand.
  task automatic measure_gap(input int exp, input string req);
    int t1 = -1; int t2 = -1;
    up_valid = 1'b1; dn_ready = 1'b1;
    for (int i = 0; i < 700 && t2 < 0; i++) begin
      if (dn_valid && up_ready) begin
        if (t1 < 0) t1 = i; else t2 = i;
      end
      tick();
    end
    up_valid = 1'b0;
    chk(t2 - t1 - 1 == exp, req, 32'(t2 - t1 - 1), 32'(exp));
    repeat (260) tick();
  endtask

  task automatic t_reset();
    logic [31:0] rd;
    up_valid = 1'b1; dn_ready = 1'b1; #1;
    chk(dn_valid && up_ready, "R1 open after reset", {30'd0, dn_valid, up_ready}, 32'h3);
    up_valid = 1'b0;
    rd_ok(rd);
    chk(rd == 32'h0, "R1 reset readback", rd, 32'h0);
  endtask

  task automatic t_layout();
    logic [31:0] rd;
    wr_ok(32'hFFFF_FFFF);
    tick();
    rd_ok(rd);
    chk(rd == 32'h0000_01FF, "R2 reserved read zero", rd, 32'h1FF);
    wr_ok(32'h0000_000B);
    tick();
    rd_ok(rd);
    chk(rd == 32'h0000_000B, "R3 supervisor 1019 read", rd, 32'hB);
    repeat (260) tick();
    measure_gap(5, "R6 gap 5");
    wr_ok(32'h0000_0101);
    measure_gap(128, "R2 FI msb at bit 8");
  endtask

  task automatic t_illegal();
    logic [31:0] rd; logic er;
    wr_ok(32'h0000_0007);
    tick();
    acc(1'b1, ID, 1'b0, 32'h0000_0021, rd, er);
    chk(er == 1'b1, "R4 user write err", {31'd0, er}, 32'h1);
    tick();
    chk(sr_err == 1'b0, "R4 err one cycle", {31'd0, sr_err}, 32'h0);
    acc(1'b1, 1018, 1'b1, 32'h0000_0021, rd, er);
    chk(er == 1'b1, "R4 bad number err", {31'd0, er}, 32'h1);
    acc(1'b0, 1018, 1'b1, '0, rd, er);
    chk(rd == 32'h0 && er, "R4 bad number read zero", rd, 32'h0);
    tick();
    rd_ok(rd);
    chk(rd == 32'h0000_0007, "R4 word unchanged", rd, 32'h7);
  endtask

  task automatic t_disabled();
    bit ok = 1'b1;
    wr_ok(32'h0000_01FE);
    for (int i = 0; i < 16; i++) begin
      up_valid = i[0] ^ i[2]; dn_ready = ~i[1]; up_data = 32'hA5A5_0000 + 32'(i * 7); #1;
      if (dn_valid != up_valid || up_ready != dn_ready) ok = 1'b0;
      chk(dn_data == up_data, "R10 data pass", dn_data, up_data);
      tick();
    end
    chk(ok, "R5 full rate while disabled", {31'd0, ok}, 32'h1);
    measure_gap(0, "R5 gap 0 disabled");
  endtask

  task automatic t_fi_zero();
    bit ok = 1'b1;
    wr_ok(32'h0000_0001);
    for (int i = 0; i < 16; i++) begin
      up_valid = i[1] | i[3]; dn_ready = i[0] | i[2]; #1;
      if (dn_valid != up_valid || up_ready != dn_ready) ok = 1'b0;
      tick();
    end
    chk(ok, "R7 FI zero matches disabled", {31'd0, ok}, 32'h1);
    measure_gap(0, "R7 gap 0 enabled");
  endtask

  task automatic start_long_gap();
    wr_ok(32'h0000_0191);
    up_valid = 1'b1; dn_ready = 1'b1;
    while (!(dn_valid && up_ready)) tick();
    tick();
    up_valid = 1'b0;
    repeat (5) tick();
  endtask

  task automatic t_clear_en();
    start_long_gap();
    chk(!up_ready, "R8 gap running", {31'd0, up_ready}, 32'h0);
    wr_ok(32'h0000_0190);
    chk(up_ready, "R8 open after disable", {31'd0, up_ready}, 32'h1);
  endtask

  task automatic t_clamp();
    int closed = 0;
    start_long_gap();
    wr_ok(32'h0000_0007);
    for (int i = 0; i < 4; i++) begin
      if (!up_ready) closed++;
      tick();
    end
    chk(closed == 3, "R9 clamp to 3", 32'(closed), 32'h3);
    chk(up_ready, "R9 open after clamp", {31'd0, up_ready}, 32'h1);
  endtask

  task automatic t_collide();
    int closed = 0;
    wr_ok(32'h0000_0005);
    repeat (4) tick();
    up_valid = 1'b1; dn_ready = 1'b1;
    sr_valid = 1'b1; sr_write = 1'b1; sr_num = 10'(ID); sr_super = 1'b1; sr_wdata = 32'h0000_000D;
    #1;
    chk(up_ready, "R11 open at collision", {31'd0, up_ready}, 32'h1);
    tick();
    sr_valid = 1'b0; up_valid = 1'b0;
    for (int i = 0; i < 7; i++) begin
      if (!up_ready) closed++;
      tick();
    end
    chk(closed == 6, "R11 new length used", 32'(closed), 32'h6);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog all-requirements actual=timeout expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; sr_valid = 1'b0; sr_write = 1'b0; sr_super = 1'b0;
    sr_num = '0; sr_wdata = '0; up_valid = 1'b0; dn_ready = 1'b0; up_data = '0;
    repeat (3) tick();
    rst_n = 1'b1;
    repeat (3) tick();
    t_reset();
    t_layout();
    t_illegal();
    t_disabled();
    t_fi_zero();
    t_clear_en();
    t_clamp();
    t_collide();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule